// File: doc/BRIEF.md
# Deferred Write Store Buffer

This block sits between a processor's write path and a single-master memory bus. Writes that may safely complete late are parked in a small first-in-first-out queue, so the processor can move on at once while the queue empties onto the bus in the background. Each incoming write is classified by its page mode and its locked flag, together with a buffer-enable bit held in a control register that reset clears. Bufferable writes go into the queue. Every other write is issued to the bus on its own, and only once everything accepted before it has completed.

The requester offers one write per cycle with `wr_valid` and sees it taken on a clock edge where `wr_ready` is also high. The bus side raises `bus_req` with a fixed address and data and keeps them unchanged until the target returns `bus_ack`. That edge completes the transfer. Page modes are coded on `wr_mode` as 00 write-through, 01 cache-inhibited imprecise, and 10 or 11 cache-inhibited precise.

Top module: `wbuf_store`

## Requirements
- R1: After reset `bus_req` is low and the buffer enable is cleared. A write-through write is therefore not queued: while it waits on the bus, a second write-through write sees `wr_ready` low.
- R2: On a clock edge with `ctl_we` high, the enable is loaded from `ctl_en_d`, which carries bit 29 of the control word. The new value governs writes from the next cycle onward.
- R3: While enabled, an unlocked write with mode 00 or 01 is deferred. It is accepted whenever fewer than DEPTH deferred entries are held, whether or not the bus is busy.
- R4: While disabled, writes with mode 00 or 01 are not deferred. Each becomes its own bus request.
- R5: A write with `wr_lock` high, or with mode 10 or 11, is never deferred, whatever the enable says.
- R6: A write that is not deferred is accepted only when no earlier write is pending, in the queue or on the bus. Until then `wr_ready` stays low for it.
- R7: Writes appear on the bus in exactly the order they were accepted, with the address and data that were accepted.
- R8: With DEPTH (default 4) deferred entries held, `wr_ready` is low for deferrable writes until an entry completes.
- R9: While `bus_req` is high and `bus_ack` is low, `bus_addr` and `bus_data` hold their values. An entry leaves the queue only on an acknowledged edge. The entry being presented on the bus still counts toward DEPTH.
- R10: Clearing the enable while entries are queued discards none of them. They still reach the bus in order.
- R11: `bus_req` is high exactly when at least one accepted write has not yet been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_en_d | input | 1 | Enable field (bit 29 of the control word) |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_mode | input | 2 | Page mode: 00 write-through, 01 inhibited imprecise, 1x inhibited precise |
| wr_lock | input | 1 | Locked write |
| wr_ready | output | 1 | Write accepted on this edge if valid |
| bus_req | output | 1 | Bus write request |
| bus_addr | output | ADDR_W | Bus address |
| bus_data | output | DATA_W | Bus data |
| bus_ack | input | 1 | Bus completes the current request |

## Verification
The bench stalls the bus so that four deferred writes fill the queue. It then expects a fifth deferrable write, a locked write and a precise write all to be refused. A design that let a bypassing write through here would reorder bus traffic, and one that miscounted occupancy would lose or overwrite an entry. The enable is dropped while the queue is full, which catches a design that flushes on disable. A run straight after reset catches an enable that comes up set, because a second write-through write would then be wrongly accepted. Long random runs with random acknowledge gaps compare every bus transfer against a program-order model, which exposes data that shifts before acknowledge.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    PG_WTHRU   = 2'b00,
    PG_NC_IMP  = 2'b01,
    PG_NC_PREC = 2'b10,
    PG_NC_PRX  = 2'b11
  } pg_mode_e;

  // A write may be parked only when buffering is on, it is unlocked,
  // and its page tolerates late completion.
  function automatic logic may_defer(input logic en, input logic [1:0] mode,
                                     input logic lock);
    return en && !lock && (mode == PG_WTHRU || mode == PG_NC_IMP);
  endfunction

endpackage

// File: rtl/wbuf_route.sv
module wbuf_route (
  input  logic       en,
  input  logic       valid,
  input  logic [1:0] mode,
  input  logic       lock,
  input  logic       fifo_full,
  input  logic       fifo_empty,
  input  logic       byp_busy,
  output logic       ready,
  output logic       push,
  output logic       byp_load
);
  import wbuf_pkg::*;

  logic defer;

  always_comb begin
    defer    = may_defer(en, mode, lock);
    ready    = defer ? !fifo_full : (fifo_empty && !byp_busy);
    push     = valid && ready && defer;
    byp_load = valid && ready && !defer;
  end

endmodule

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CAP);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CAP));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

endmodule

// File: rtl/wbuf_bus.sv
module wbuf_bus #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         byp_load,
  input  logic [W-1:0] byp_word,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_word,
  input  logic         bus_ack,
  output logic         bus_req,
  output logic [W-1:0] bus_word,
  output logic         byp_busy,
  output logic         fifo_pop
);
  logic         byp_q;
  logic [W-1:0] byp_word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b0;
    end else if (byp_load) begin
      byp_q <= 1'b1;
    end else if (bus_ack && byp_q) begin
      byp_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (byp_load) byp_word_q <= byp_word;
  end

  // a bypass write is only loaded with the queue empty, so it is older
  // than everything queued and takes the bus first
  always_comb begin
    bus_req  = byp_q || !fifo_empty;
    bus_word = byp_q ? byp_word_q : fifo_word;
    fifo_pop = bus_ack && !byp_q && !fifo_empty;
    byp_busy = byp_q;
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_word)));

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_en_d,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_mode,
  input  logic              wr_lock,
  output logic              wr_ready,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic              bus_ack
);
  localparam int W = ADDR_W + DATA_W;

  logic         en_q;
  logic         push, byp_load, fifo_pop;
  logic         fifo_empty, fifo_full, byp_busy;
  logic [W-1:0] in_word, fifo_word, bus_word;

  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (ctl_we) en_q <= ctl_en_d;
  end

  assign in_word = {wr_addr, wr_data};

  wbuf_route u_route (
    .en         (en_q),
    .valid      (wr_valid),
    .mode       (wr_mode),
    .lock       (wr_lock),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .byp_busy   (byp_busy),
    .ready      (wr_ready),
    .push       (push),
    .byp_load   (byp_load)
  );

  wbuf_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (in_word),
    .pop   (fifo_pop),
    .rdata (fifo_word),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  wbuf_bus #(.W(W)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .byp_load   (byp_load),
    .byp_word   (in_word),
    .fifo_empty (fifo_empty),
    .fifo_word  (fifo_word),
    .bus_ack    (bus_ack),
    .bus_req    (bus_req),
    .bus_word   (bus_word),
    .byp_busy   (byp_busy),
    .fifo_pop   (fifo_pop)
  );

  assign bus_addr = bus_word[W-1:DATA_W];
  assign bus_data = bus_word[DATA_W-1:0];

  // R1
  en_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !en_q);

  // R6
  byp_order_chk: assert property (@(posedge clk) disable iff (rst)
    byp_load |-> !bus_req);

endmodule

// File: tb/wbuf_store_tb.sv
`timescale 1ns/1ps
module wbuf_store_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          ctl_we, ctl_en_d;
  logic          wr_valid, wr_lock, wr_ready;
  logic [AW-1:0] wr_addr, bus_addr;
  logic [DW-1:0] wr_data, bus_data;
  logic [1:0]    wr_mode;
  logic          bus_req, bus_ack;

  always #2.5 clk = ~clk;

  wbuf_store #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_en_d(ctl_en_d),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mode(wr_mode), .wr_lock(wr_lock), .wr_ready(wr_ready),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ack(bus_ack)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // program-order model of accepted writes not yet acknowledged
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];
  bit            q_byp[$];
  int            n_fifo = 0;
  bit            m_en = 0;
  logic          last_rdy;

  function automatic bit exp_defer(bit en, logic [1:0] m, logic lk);
    return en && !lk && (m == 2'b00 || m == 2'b01);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m, input logic lk,
                      input logic ak, input logic cwe, input logic cen,
                      input string tag);
    bit   d, exp_rdy, ackd, acc;
    wr_valid = v; wr_mode = m; wr_lock = lk;
    wr_addr = $urandom; wr_data = $urandom;
    bus_ack = ak; ctl_we = cwe; ctl_en_d = cen;
    #1;
    d = exp_defer(m_en, m, lk);
    exp_rdy = d ? (n_fifo < DEPTH) : (q_addr.size() == 0);
    chk(wr_ready === exp_rdy, {tag, " ready"}, 64'(wr_ready), 64'(exp_rdy));
    chk(bus_req === (q_addr.size() != 0), "R11 bus_req",
        64'(bus_req), 64'(q_addr.size() != 0));
    last_rdy = wr_ready;
    ackd = bus_req && ak;
    if (ackd && q_addr.size() != 0)
      chk(bus_addr === q_addr[0] && bus_data === q_data[0], "R7/R9 bus word",
          {bus_addr, bus_data}, {q_addr[0], q_data[0]});
    acc = v && wr_ready;
    @(posedge clk);
    if (ackd && q_addr.size() != 0) begin
      if (!q_byp[0]) n_fifo--;
      void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_byp.pop_front());
    end
    if (acc) begin
      q_addr.push_back(wr_addr); q_data.push_back(wr_data); q_byp.push_back(!d);
      if (d) n_fifo++;
    end
    if (cwe) m_en = cen;
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 60 && q_addr.size() != 0; i++)
      step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, tag);
    chk(q_addr.size() == 0, {tag, " drained"}, 64'(q_addr.size()), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7133));
    rst = 1'b1; wr_valid = 0; wr_mode = 0; wr_lock = 0; wr_addr = 0; wr_data = 0;
    bus_ack = 0; ctl_we = 0; ctl_en_d = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(bus_req === 1'b0, "R1 bus_req after reset", 64'(bus_req), 64'd0);

    // R1/R4: enable comes up cleared, write-through goes straight to the bus
    step(1, 2'b00, 0, 0, 0, 0, "R1");
    chk(last_rdy === 1'b1, "R1 first wt accepted", 64'(last_rdy), 64'd1);
    step(1, 2'b00, 0, 0, 0, 0, "R1");
    chk(last_rdy === 1'b0, "R1/R4 second wt held", 64'(last_rdy), 64'd0);
    step(1, 2'b01, 0, 0, 0, 0, "R4");
    chk(last_rdy === 1'b0, "R4 imprecise held", 64'(last_rdy), 64'd0);
    drain("R4");

    // R2: turn buffering on
    step(0, 2'b00, 0, 0, 1, 1, "R2");
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 2'(i % 2), 0, 0, 0, 0, "R3");
      chk(last_rdy === 1'b1, "R3 deferred accepted", 64'(last_rdy), 64'd1);
    end
    step(1, 2'b00, 0, 0, 0, 0, "R8");
    chk(last_rdy === 1'b0, "R8 full stall", 64'(last_rdy), 64'd0);
    step(1, 2'b00, 1, 0, 0, 0, "R5");
    chk(last_rdy === 1'b0, "R5/R6 locked held", 64'(last_rdy), 64'd0);
    step(1, 2'b10, 0, 0, 0, 0, "R5");
    chk(last_rdy === 1'b0, "R5/R6 precise held", 64'(last_rdy), 64'd0);
    // R10: disable with entries pending, nothing lost
    step(0, 2'b00, 0, 0, 1, 0, "R10");
    chk(bus_req === 1'b1, "R10 still pending", 64'(bus_req), 64'd1);
    drain("R10");

    // R5/R7: locked write on an idle bus, then deferred writes behind it
    step(0, 2'b00, 0, 0, 1, 1, "R2");
    step(1, 2'b01, 1, 0, 0, 0, "R5");
    chk(last_rdy === 1'b1, "R5 locked accepted idle", 64'(last_rdy), 64'd1);
    step(1, 2'b00, 0, 0, 0, 0, "R7");
    step(1, 2'b01, 0, 0, 0, 0, "R7");
    step(1, 2'b11, 0, 0, 0, 0, "R5");
    chk(last_rdy === 1'b0, "R5 mode 11 held", 64'(last_rdy), 64'd0);
    drain("R7");

    // random traffic
    for (int i = 0; i < 5000; i++)
      step(($urandom % 10) < 6, 2'($urandom % 4), ($urandom % 8) == 0,
           ($urandom % 10) < 4, ($urandom % 64) == 0, 1'($urandom % 2),
           "R3/R4/R5/R6");
    drain("R7");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule